// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

This block is one programmable logic cell of the kind found in a sum-of-products device. It has 18 logic inputs and four outputs. A serially loaded configuration word sets all of its behaviour. An AND array builds 20 product terms from the true and inverted inputs. Sixteen of these terms feed four macrocells, four terms to each. The other four are shared control terms: a clock term, a reset term, an output-enable term and a spare operand for the exclusive-OR stage.

Each macrocell takes one of two paths. The fast path is a plain OR of its four terms. The full path passes that OR through an exclusive-OR with the spare term and a polarity bit. The macrocell then drives that value straight out, or through a flip-flop. All flip-flops in the block share one clock, picked by the configuration from three global clocks or the clock product term. They clear asynchronously when the global active-low reset is asserted or the reset term is true.

In use, the configuration is shifted in with the load enable high, and the load enable is then dropped. Until the load completes, every output is held low.

Top module: `ptl_block`

## Requirements
- R1: While `cfgLoad` is high, each rising `cfgClk` edge shifts `cfgDin` into the top of a 738-bit configuration register (toward bit 0), so that the first bit sent ends in bit 0. The load-complete flag clears on any edge with `cfgLoad` high. It sets on the first edge with `cfgLoad` low that follows such a load.
- R2: While the load-complete flag is clear, `dataOut` and `oeOut` are all zero, whatever the inputs.
- R3: Product term p (0..19) uses configuration bits p*36+2i (require input i high) and p*36+2i+1 (require input i low). A term with both bits set for any input is false. A term with no bits set is true.
- R4: Macrocell m (0..3) owns terms 4m..4m+3. Its configuration nibble sits at bit 720+4m: bit 0 registered, bit 1 fast, bit 2 spare-XOR enable, bit 3 invert. On the fast path the value is the OR of its four terms, and the spare-XOR and invert bits have no effect.
- R5: On the full path the value is the OR of its four terms, XORed with term 19 when spare-XOR is set, and inverted when invert is set.
- R6: A macrocell whose registered bit is 0 drives its path value combinatorially. With the bit at 1 it drives a flip-flop that loads the path value only on an edge of the selected clock.
- R7: Bits 737:736 select the block clock: 0, 1, 2 pick `yClk[0]`, `yClk[1]`, `yClk[2]`, and 3 picks product term 16. Edges on the other sources are ignored.
- R8: The flip-flops clear at once while `rstN` is low or term 17 is true, and the clear overrides a simultaneous clock edge.
- R9: `oeOut` equals product term 18 once loading is complete.
- R10: A low `rstN` clears the load-complete flag, so outputs stay low after reset until the configuration is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | Configuration shift clock |
| cfgLoad | input | 1 | Configuration shift enable |
| cfgDin | input | 1 | Serial configuration data |
| rstN | input | 1 | Global active-low reset |
| yClk | input | 3 | Global clock candidates |
| dIn | input | 18 | Logic inputs |
| dataOut | output | 4 | Macrocell outputs |
| oeOut | output | 1 | Output-enable term for driven I/O |

## Verification
A wrong configuration bit changes a product term, and a combinatorial macrocell shows it at `dataOut` in the same moment the inputs change. The table of input patterns exposes misplaced mask bits, path or polarity errors within one step. A register that captures on the wrong clock source, or fails to clear, shows up only at the next pulse of a clock candidate or reset term. So every clock source is pulsed on its own, with the expected value checked right after each pulse. A stuck load-complete flag shows as outputs that stay dark, or come alive too early, right after a reset or during a reload.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
  localparam int NUM_IN       = 18;
  localparam int NUM_MC       = 4;
  localparam int PT_PER_MC    = 4;
  localparam int NUM_CTRL_PT  = 4;
  localparam int NUM_PT       = NUM_MC * PT_PER_MC + NUM_CTRL_PT;
  localparam int PT_CFG_W     = 2 * NUM_IN;
  localparam int MC_CFG_W     = 4;
  localparam int NUM_CLK      = 3;
  localparam int SEL_W        = 2;
  localparam int PT_FIELD_W   = NUM_PT * PT_CFG_W;
  localparam int MC_FIELD_W   = NUM_MC * MC_CFG_W;
  localparam int MC_FIELD_LSB = PT_FIELD_W;
  localparam int SEL_LSB      = MC_FIELD_LSB + MC_FIELD_W;
  localparam int CFG_W        = SEL_LSB + SEL_W;

  localparam int PT_CLK_IDX = NUM_MC * PT_PER_MC;
  localparam int PT_RST_IDX = PT_CLK_IDX + 1;
  localparam int PT_OE_IDX  = PT_CLK_IDX + 2;
  localparam int PT_XOR_IDX = PT_CLK_IDX + 3;

  typedef struct packed {
    logic invert;
    logic xorSpare;
    logic fast;
    logic registered;
  } mc_cfg_t;

  typedef struct packed {
    logic macroClk;
    logic regClr;
    logic outEn;
  } strobe_t;
endpackage

// File: rtl/ptl_pterm.sv
module ptl_pterm #(
  parameter int N = ptl_pkg::NUM_IN
) (
  input  logic [N-1:0]   dIn,
  input  logic [2*N-1:0] mask,
  output logic           term
);
  logic [N-1:0] litOk;

  for (genvar i = 0; i < N; i++) begin : g_lit
    // true-select demands a high input, complement-select a low one
    assign litOk[i] = ~(mask[2*i] & ~dIn[i]) & ~(mask[2*i+1] & dIn[i]);
  end

  assign term = &litOk;
endmodule

// File: rtl/ptl_macrocell.sv
module ptl_macrocell
  import ptl_pkg::*;
#(
  parameter int TERMS = PT_PER_MC
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [TERMS-1:0] terms,
  input  logic             xorTerm,
  input  mc_cfg_t          cfg,
  output logic             cellOut,
  output logic             regQ
);
  logic sumVal;
  logic fullVal;
  logic pathVal;

  assign sumVal  = |terms;
  assign fullVal = sumVal ^ (cfg.xorSpare & xorTerm) ^ cfg.invert;
  assign pathVal = cfg.fast ? sumVal : fullVal;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) regQ <= 1'b0;
    else     regQ <= pathVal;
  end

  assign cellOut = cfg.registered ? regQ : pathVal;
endmodule

// File: rtl/ptl_datapath.sv
module ptl_datapath
  import ptl_pkg::*;
(
  input  logic [NUM_IN-1:0]     dIn,
  input  logic [PT_FIELD_W-1:0] ptMask,
  input  logic [MC_FIELD_W-1:0] mcCfg,
  input  strobe_t               strobes,
  output logic [NUM_MC-1:0]     dataOut,
  output logic                  oeOut,
  output logic                  ptClk,
  output logic                  ptRst,
  output logic                  ptOe,
  output logic [NUM_MC-1:0]     regQ
);
  logic [NUM_PT-1:0] terms;
  logic [NUM_MC-1:0] cellOut;

  for (genvar p = 0; p < NUM_PT; p++) begin : g_pt
    ptl_pterm #(.N(NUM_IN)) i_pterm (
      .dIn  (dIn),
      .mask (ptMask[p*PT_CFG_W +: PT_CFG_W]),
      .term (terms[p])
    );
  end

  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    ptl_macrocell #(.TERMS(PT_PER_MC)) i_cell (
      .clk     (strobes.macroClk),
      .clr     (strobes.regClr),
      .terms   (terms[m*PT_PER_MC +: PT_PER_MC]),
      .xorTerm (terms[PT_XOR_IDX]),
      .cfg     (mc_cfg_t'(mcCfg[m*MC_CFG_W +: MC_CFG_W])),
      .cellOut (cellOut[m]),
      .regQ    (regQ[m])
    );
  end

  assign ptClk   = terms[PT_CLK_IDX];
  assign ptRst   = terms[PT_RST_IDX];
  assign ptOe    = terms[PT_OE_IDX];
  assign dataOut = strobes.outEn ? cellOut : '0;
  assign oeOut   = strobes.outEn & ptOe;
endmodule

// File: rtl/ptl_ctrl.sv
module ptl_ctrl
  import ptl_pkg::*;
(
  input  logic                  cfgClk,
  input  logic                  rstN,
  input  logic                  cfgLoad,
  input  logic                  cfgDin,
  input  logic [NUM_CLK-1:0]    yClk,
  input  logic                  ptClk,
  input  logic                  ptRst,
  output logic [PT_FIELD_W-1:0] ptMask,
  output logic [MC_FIELD_W-1:0] mcCfg,
  output strobe_t               strobes
);
  logic [CFG_W-1:0]   cfgReg;
  logic               loadSeen;
  logic               cfgDone;
  logic [NUM_CLK:0]   clkSrc;
  logic [SEL_W-1:0]   clkSel;
  logic               selClk;

  always_ff @(posedge cfgClk) begin
    if (cfgLoad) cfgReg <= {cfgDin, cfgReg[CFG_W-1:1]};
  end

  always_ff @(posedge cfgClk or negedge rstN) begin
    if (!rstN) begin
      loadSeen <= 1'b0;
      cfgDone  <= 1'b0;
    end else if (cfgLoad) begin
      loadSeen <= 1'b1;
      cfgDone  <= 1'b0;
    end else if (loadSeen) begin
      loadSeen <= 1'b0;
      cfgDone  <= 1'b1;
    end
  end

  assign clkSrc = {ptClk, yClk};
  assign clkSel = cfgReg[SEL_LSB +: SEL_W];
  assign selClk = clkSrc[clkSel];

  assign ptMask = cfgReg[PT_FIELD_W-1:0];
  assign mcCfg  = cfgReg[MC_FIELD_LSB +: MC_FIELD_W];

  // no clock or term-driven clear reaches the cells until loading is done
  assign strobes.macroClk = cfgDone & selClk;
  assign strobes.regClr   = ~rstN | (cfgDone & ptRst);
  assign strobes.outEn    = cfgDone;
endmodule

// File: rtl/ptl_block.sv
module ptl_block
  import ptl_pkg::*;
(
  input  logic                cfgClk,
  input  logic                cfgLoad,
  input  logic                cfgDin,
  input  logic                rstN,
  input  logic [NUM_CLK-1:0]  yClk,
  input  logic [NUM_IN-1:0]   dIn,
  output logic [NUM_MC-1:0]   dataOut,
  output logic                oeOut
);
  strobe_t               strobes;
  logic [PT_FIELD_W-1:0] ptMask;
  logic [MC_FIELD_W-1:0] mcCfg;
  logic                  ptClk;
  logic                  ptRst;
  logic                  ptOe;
  logic [NUM_MC-1:0]     regQ;
  logic                  outEn;
  logic                  regClr;

  ptl_ctrl i_ctrl (
    .cfgClk  (cfgClk),
    .rstN    (rstN),
    .cfgLoad (cfgLoad),
    .cfgDin  (cfgDin),
    .yClk    (yClk),
    .ptClk   (ptClk),
    .ptRst   (ptRst),
    .ptMask  (ptMask),
    .mcCfg   (mcCfg),
    .strobes (strobes)
  );

  ptl_datapath i_dp (
    .dIn     (dIn),
    .ptMask  (ptMask),
    .mcCfg   (mcCfg),
    .strobes (strobes),
    .dataOut (dataOut),
    .oeOut   (oeOut),
    .ptClk   (ptClk),
    .ptRst   (ptRst),
    .ptOe    (ptOe),
    .regQ    (regQ)
  );

  assign outEn  = strobes.outEn;
  assign regClr = strobes.regClr;
endmodule

// File: rtl/ptl_block_chk.sv
module ptl_block_chk
  import ptl_pkg::*;
(
  input logic              cfgClk,
  input logic              rstN,
  input logic              cfgLoad,
  input logic              doneFlag,
  input logic [NUM_MC-1:0] dataOut,
  input logic              oeOut,
  input logic              ptOe,
  input logic              regClr,
  input logic [NUM_MC-1:0] regQ
);
  p_load_clears_done_r1: assert property (@(posedge cfgClk) disable iff (!rstN)
    cfgLoad |=> !doneFlag);

  p_dark_until_done_r2: assert property (@(posedge cfgClk) disable iff (!rstN)
    !doneFlag |-> (dataOut == '0 && !oeOut));

  p_clear_empties_regs_r8: assert property (@(posedge cfgClk) disable iff (!rstN)
    regClr |-> regQ == '0);

  p_oe_follows_term_r9: assert property (@(posedge cfgClk) disable iff (!rstN)
    doneFlag |-> oeOut == ptOe);
endmodule

bind ptl_block ptl_block_chk i_chk (
  .cfgClk   (cfgClk),
  .rstN     (rstN),
  .cfgLoad  (cfgLoad),
  .doneFlag (outEn),
  .dataOut  (dataOut),
  .oeOut    (oeOut),
  .ptOe     (ptOe),
  .regClr   (regClr),
  .regQ     (regQ)
);

// File: tb/test_ptl_block.sv
`timescale 1ns/1ps
module test_ptl_block;
  localparam int CW   = 738;
  localparam int PTW  = 36;
  localparam int MCL  = 720;
  localparam int SELL = 736;

  logic        cfgClk = 1'b0;
  logic        cfgLoad = 1'b0;
  logic        cfgDin = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  yClk = 3'b000;
  logic [17:0] dIn = '0;
  logic [3:0]  dataOut;
  logic        oeOut;

  logic [CW-1:0] cv;
  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  ptl_block i_ptl_block (
    .cfgClk (cfgClk), .cfgLoad (cfgLoad), .cfgDin (cfgDin), .rstN (rstN),
    .yClk (yClk), .dIn (dIn), .dataOut (dataOut), .oeOut (oeOut)
  );

  always #2 cfgClk = ~cfgClk;

  // {inputs, expected dataOut, expected oeOut} under configuration A
  localparam logic [22:0] TABLE [9] = '{
    {18'h00000, 4'b0000, 1'b1},
    {18'h00003, 4'b0001, 1'b1},
    {18'h10008, 4'b0010, 1'b0},
    {18'h0001C, 4'b0100, 1'b1},
    {18'h00330, 4'b1000, 1'b1},
    {18'h00701, 4'b0000, 1'b1},
    {18'h20023, 4'b1101, 1'b1},
    {18'h3FFFF, 4'b1001, 1'b0},
    {18'h10088, 4'b1010, 1'b0}
  };

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s: actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic ptLit(input int p, input int i, input bit comp);
    cv[p*PTW + 2*i + (comp ? 1 : 0)] = 1'b1;
  endtask

  task automatic ptOff(input int p);
    cv[p*PTW] = 1'b1;
    cv[p*PTW + 1] = 1'b1;
  endtask

  task automatic mcSet(input int m, input bit r, input bit f, input bit x, input bit v);
    cv[MCL + 4*m +: 4] = {v, x, f, r};
  endtask

  task automatic buildA();
    cv = '0;
    ptLit(0, 0, 0); ptLit(0, 1, 0); ptOff(1); ptOff(2); ptOff(3);
    mcSet(0, 0, 1, 1, 1);
    ptLit(4, 2, 0); ptLit(5, 3, 1); ptOff(6); ptOff(7);
    mcSet(1, 0, 0, 0, 1);
    ptLit(8, 4, 0); ptOff(9); ptOff(10); ptOff(11);
    mcSet(2, 0, 0, 1, 0);
    ptLit(12, 6, 0); ptLit(13, 7, 0);
    ptLit(14, 8, 0); ptLit(14, 9, 0); ptLit(14, 10, 1); ptLit(15, 17, 0);
    mcSet(3, 0, 1, 0, 0);
    ptOff(16); ptOff(17); ptLit(18, 16, 1); ptLit(19, 5, 0);
    cv[SELL +: 2] = 2'd0;
  endtask

  task automatic buildB(input int s);
    cv = '0;
    ptLit(0, 0, 0); ptOff(1); ptOff(2); ptOff(3);
    mcSet(0, 1, 1, 0, 0);
    ptLit(4, 1, 0); ptOff(5); ptOff(6); ptOff(7);
    mcSet(1, 1, 0, 0, 1);
    ptOff(9); ptOff(10); ptOff(11);
    mcSet(2, 0, 1, 0, 0);
    ptLit(12, 2, 0); ptOff(13); ptOff(14); ptOff(15);
    mcSet(3, 1, 1, 0, 0);
    ptLit(16, 14, 0); ptLit(17, 15, 0); ptOff(19);
    cv[SELL +: 2] = s[1:0];
  endtask

  task automatic loadCfg();
    @(negedge cfgClk);
    cfgLoad = 1'b1;
    for (int i = 0; i < CW; i++) begin
      cfgDin = cv[i];
      @(negedge cfgClk);
      if (i == CW / 2) check("R1 outputs dark during load", {dataOut, oeOut}, 5'b00000);
    end
    cfgLoad = 1'b0;
    cfgDin = 1'b0;
    @(negedge cfgClk);
    @(negedge cfgClk);
  endtask

  task automatic pulseY(input int k);
    yClk[k] = 1'b1; #1;
    yClk[k] = 1'b0; #1;
  endtask

  task automatic pulsePtClk();
    dIn[14] = 1'b1; #1;
    dIn[14] = 1'b0; #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    dIn = '1;
    #5;
    check("R2 R10 reset state dark", {dataOut, oeOut}, 5'b00000);
    rstN = 1'b1;
    #3;
    check("R2 dark before any load", {dataOut, oeOut}, 5'b00000);
    dIn = '0;

    // combinational table: R3 R4 R5 R6 R9
    buildA();
    loadCfg();
    for (int k = 0; k < 9; k++) begin
      dIn = TABLE[k][22:5];
      #2;
      check($sformatf("R3 R4 R5 R9 table row %0d", k), {dataOut, oeOut}, TABLE[k][4:0]);
    end

    // registered config on Y0
    dIn = '0;
    buildB(0);
    loadCfg();
    #1;
    check("R3 empty term true, regs idle", {dataOut, oeOut}, 5'b01001);
    dIn = 18'h00005;
    #1;
    check("R6 registered holds before edge", {dataOut, oeOut}, 5'b01001);
    pulseY(0);
    check("R6 R4 R5 capture on Y0", {dataOut, oeOut}, 5'b11111);
    dIn[15] = 1'b1;
    #1;
    check("R8 reset term clears", {dataOut, oeOut}, 5'b01001);
    pulseY(0);
    check("R8 clear overrides clock", {dataOut, oeOut}, 5'b01001);
    dIn[15] = 1'b0;
    #1;
    check("R8 stays clear after release", {dataOut, oeOut}, 5'b01001);

    // clock source selection R7
    for (int s = 0; s < 4; s++) begin
      dIn = '0;
      buildB(s);
      loadCfg();
      dIn[15] = 1'b1; #1; dIn[15] = 1'b0; #1;
      dIn[0] = 1'b1;
      #1;
      for (int k = 0; k < 3; k++) begin
        if (k != s) begin
          pulseY(k);
          check($sformatf("R7 sel %0d ignores y%0d", s, k), {dataOut, oeOut}, 5'b01001);
        end
      end
      if (s != 3) begin
        pulsePtClk();
        check($sformatf("R7 sel %0d ignores term clock", s), {dataOut, oeOut}, 5'b01001);
        pulseY(s);
      end else begin
        pulsePtClk();
      end
      check($sformatf("R7 sel %0d captures", s), {dataOut, oeOut}, 5'b01111);
    end

    // global reset R8 R10
    dIn = '0;
    buildB(0);
    loadCfg();
    dIn = 18'h00005;
    pulseY(0);
    check("R6 preload before reset", {dataOut, oeOut}, 5'b11111);
    rstN = 1'b0;
    #1;
    check("R10 reset darkens outputs", {dataOut, oeOut}, 5'b00000);
    rstN = 1'b1;
    #3;
    check("R10 dark until reload", {dataOut, oeOut}, 5'b00000);
    dIn = '0;
    loadCfg();
    #1;
    check("R8 global reset cleared regs", {dataOut, oeOut}, 5'b01001);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule